// File: doc/BRIEF.md
# Uncore Event Counter Unit

This block is a memory-mapped performance monitor for an I/O complex. It has eight 64-bit counters. Each counter has its own 8-bit event selector, which picks one strobe from two I/O ports or from an external agent. Each port offers five strobes: active cycles, reads, bus reads, writes and bus writes. Software reaches the unit through a single-cycle register port with 64-bit data and word addresses. Writes take effect at the next rising clock edge. Reads return the current register contents without delay.

Counting needs two things: the global enable bit and the counter's own enable bit. Per-counter enables and interrupt enables are changed through paired write-one-to-set and write-one-to-clear words. When a counter wraps from all ones to zero, its sticky overflow bit is set. Software clears that bit by writing a one to it. A level interrupt is raised while any overflow bit whose interrupt enable is set is high. A self-clearing unit reset bit in the global control word returns the whole monitor to its reset state in one cycle.

Top module: `ucnt_unit`

## Requirements
- R1: After the active-low synchronous reset, every counter, event selector, enable mask, interrupt enable mask, overflow bit and the global enable read as zero, and the interrupt output is low.
- R2: A counter advances by exactly one on each clock edge where all of the following hold: its selected strobe is high, the global enable is set, and its own enable is set. In every other cycle it holds its value. Its live value reads at word 0x00+n.
- R3: The 8-bit event selector is at word 0x40+n and reads back zero-extended. Port 0 codes are cycles 0x00, reads 0x10, bus reads 0x14, writes 0x20 and bus writes 0x24. These map to port0_ev bits 0 to 4. Port 1 uses 0x40, 0x50, 0x54, 0x60 and 0x64, mapped to port1_ev bits 0 to 4. Code 0x80 selects ext_ev.
- R4: A counter whose selector holds any other code never counts.
- R5: Bit 0 of the global control word (word 0x80) is the global enable, and the word reads back only that bit. Writing 0 stops every counter whatever its own enable.
- R6: Writing word 0x82 sets the counter enable bits that are 1 in the data. Writing word 0x83 clears them. Zero data bits leave enables unchanged, and both words read back the current enable mask.
- R7: Interrupt enables use the same scheme at word 0x84 (set) and word 0x85 (clear), and both words read back the current mask.
- R8: When counter n wraps from all ones to zero, bit n of the overflow word (word 0x88) is set. Writing 1 to a bit clears it, and 0 bits have no effect. A wrap in the same cycle as a clear leaves the bit set.
- R9: The interrupt output is high exactly while some counter has both its overflow bit and its interrupt enable bit set.
- R10: Writing a counter word loads the data into the counter. In that cycle the write takes precedence over any increment, and no overflow is recorded.
- R11: Writing bit 1 of the global control word clears all counters, selectors, enables, interrupt enables and overflow bits at that edge. The bit reads back as zero, and the global enable takes bit 0 of the same write.
- R12: The per-counter control words (0x20+n) and all unmapped words read as zero. Writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wen | input | 1 | Register write strobe for this cycle |
| bus_addr | input | ADDR_W | Word address for both read and write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| port0_ev | input | 5 | Port 0 strobes: cycles, read, bus read, write, bus write |
| port1_ev | input | 5 | Port 1 strobes, same order |
| ext_ev | input | 1 | External-agent strobe |
| irq | output | 1 | Level interrupt |

## Verification
The bench goes after the counter wrap: a counter loaded just below all ones must roll to zero, raise its overflow bit and drive the interrupt. A design with an off-by-one compare would flag the wrap a cycle early or never. Two same-cycle collisions are forced on purpose. In the first, an increment coincides with a software load; a design that let the increment win would read one too many. In the second, a wrap coincides with an overflow clear; a design that let the clear win would silently lose an overflow. Each of the eleven event codes is exercised while all the other strobes stay high, so a mis-decoded code shows up as an inflated count. A reset bit that failed to self-clear would read back in the control word.

// File: rtl/ucnt_pkg.sv
// Shared constants and types for the uncore event counter unit.
// Assumes word addressing: one address step is one 64-bit register.
package ucnt_pkg;

    // Word addresses of the register banks and singletons
    localparam logic [7:0] A_CNT_BASE = 8'h00;
    localparam logic [7:0] A_CTL_BASE = 8'h20;
    localparam logic [7:0] A_SEL_BASE = 8'h40;
    localparam logic [7:0] A_GCTRL    = 8'h80;
    localparam logic [7:0] A_ENSET    = 8'h82;
    localparam logic [7:0] A_ENCLR    = 8'h83;
    localparam logic [7:0] A_IESET    = 8'h84;
    localparam logic [7:0] A_IECLR    = 8'h85;
    localparam logic [7:0] A_OVF      = 8'h88;

    // Strobes per port and the external-agent code
    localparam int         NEV      = 5;
    localparam logic [7:0] EV_EXT   = 8'h80;
    localparam logic [7:0] P1_OFSET = 8'h40;

    typedef enum logic [3:0] {
        K_NONE, K_CNT, K_CTL, K_SEL, K_GCTRL,
        K_ENSET, K_ENCLR, K_IESET, K_IECLR, K_OVF
    } reg_kind_e;

    // Event code of strobe e on port 0 or port 1
    function automatic logic [7:0] ev_code(input logic second_port, input int e);
        logic [7:0] base;
        case (e)
            0:       base = 8'h00;
            1:       base = 8'h10;
            2:       base = 8'h14;
            3:       base = 8'h20;
            default: base = 8'h24;
        endcase
        return second_port ? (base + P1_OFSET) : base;
    endfunction

endpackage

// File: rtl/ucnt_decode.sv
// Address decoder: classifies a word address into a register kind and a
// counter index. Assumes the banks are 0x20 words apart and NCNT <= 32.
module ucnt_decode
    import ucnt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NCNT   = 8,
    parameter int IDX_W  = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [IDX_W-1:0]  idx
);

    function automatic logic in_bank(input logic [ADDR_W-1:0] a, input logic [7:0] base);
        return (a >= ADDR_W'(base)) && (a < ADDR_W'(base) + ADDR_W'(NCNT));
    endfunction

    // Bank range match first, then exact singleton match
    always_comb begin
        kind = K_NONE;
        idx  = '0;
        if (in_bank(addr, A_CNT_BASE)) begin
            kind = K_CNT;
            idx  = IDX_W'(addr - ADDR_W'(A_CNT_BASE));
        end else if (in_bank(addr, A_CTL_BASE)) begin
            kind = K_CTL;
            idx  = IDX_W'(addr - ADDR_W'(A_CTL_BASE));
        end else if (in_bank(addr, A_SEL_BASE)) begin
            kind = K_SEL;
            idx  = IDX_W'(addr - ADDR_W'(A_SEL_BASE));
        end else begin
            case (addr)
                ADDR_W'(A_GCTRL): kind = K_GCTRL;
                ADDR_W'(A_ENSET): kind = K_ENSET;
                ADDR_W'(A_ENCLR): kind = K_ENCLR;
                ADDR_W'(A_IESET): kind = K_IESET;
                ADDR_W'(A_IECLR): kind = K_IECLR;
                ADDR_W'(A_OVF):   kind = K_OVF;
                default:          kind = K_NONE;
            endcase
        end
    end

endmodule

// File: rtl/ucnt_evsel.sv
// Event selector: returns the strobe named by an event code, or 0 for an
// unassigned code. Purely combinational.
module ucnt_evsel
    import ucnt_pkg::*;
#(
    parameter int SEL_W = 8
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [NEV-1:0]   port0_ev,
    input  logic [NEV-1:0]   port1_ev,
    input  logic             ext_ev,
    output logic             hit
);

    // Compare the selector against every assigned code
    always_comb begin
        hit = (sel == SEL_W'(EV_EXT)) && ext_ev;
        for (int e = 0; e < NEV; e++) begin
            if (sel == SEL_W'(ev_code(1'b0, e))) hit = port0_ev[e];
            if (sel == SEL_W'(ev_code(1'b1, e))) hit = port1_ev[e];
        end
    end

endmodule

// File: rtl/ucnt_slice.sv
// One counter slice: event selector register, decoder and counter.
// Priority at the clock edge: unit clear, then software load, then increment.
// The wrap flag goes high only when an increment actually rolls the counter over.
module ucnt_slice
    import ucnt_pkg::*;
#(
    parameter int CNT_W = 64,
    parameter int SEL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             unit_clr,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             sel_we,
    input  logic [SEL_W-1:0] sel_wdata,
    input  logic             run,
    input  logic [NEV-1:0]   port0_ev,
    input  logic [NEV-1:0]   port1_ev,
    input  logic             ext_ev,
    output logic [CNT_W-1:0] cnt_q,
    output logic [SEL_W-1:0] sel_q,
    output logic             wrap
);

    logic hit;
    logic inc;

    ucnt_evsel #(.SEL_W(SEL_W)) u_evsel (
        .sel      (sel_q),
        .port0_ev (port0_ev),
        .port1_ev (port1_ev),
        .ext_ev   (ext_ev),
        .hit      (hit)
    );

    assign inc  = run && hit;
    assign wrap = inc && !cnt_we && !unit_clr && (cnt_q == '1);

    // Event selector register
    always_ff @(posedge clk) begin
        if (!rst_n || unit_clr) sel_q <= '0;
        else if (sel_we)        sel_q <= sel_wdata;
    end

    // Counter register
    always_ff @(posedge clk) begin
        if (!rst_n || unit_clr) cnt_q <= '0;
        else if (cnt_we)        cnt_q <= cnt_wdata;
        else if (inc)           cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/ucnt_unit.sv
// Uncore event counter unit top: register port, global control, enable and
// interrupt-enable masks, overflow status, interrupt, and NCNT counter slices.
// Assumes CNT_W <= DATA_W, NCNT <= DATA_W, SEL_W <= DATA_W and ADDR_W >= 8.
module ucnt_unit
    import ucnt_pkg::*;
#(
    parameter int NCNT   = 8,
    parameter int CNT_W  = 64,
    parameter int DATA_W = 64,
    parameter int ADDR_W = 8,
    parameter int SEL_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wen,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NEV-1:0]    port0_ev,
    input  logic [NEV-1:0]    port1_ev,
    input  logic              ext_ev,
    output logic              irq
);

    localparam int IDX_W = (NCNT > 1) ? $clog2(NCNT) : 1;

    reg_kind_e                      kind;
    logic [IDX_W-1:0]               idx;
    logic                           unit_clr;
    logic                           gen_en_q;
    logic [NCNT-1:0]                en_q;
    logic [NCNT-1:0]                inten_q;
    logic [NCNT-1:0]                ovf_q;
    logic [NCNT-1:0]                wrap_v;
    logic [NCNT-1:0]                wmask;
    logic [NCNT-1:0][CNT_W-1:0]     cnt_arr;
    logic [NCNT-1:0][SEL_W-1:0]     sel_arr;

    ucnt_decode #(.ADDR_W(ADDR_W), .NCNT(NCNT), .IDX_W(IDX_W)) u_dec (
        .addr (bus_addr),
        .kind (kind),
        .idx  (idx)
    );

    assign wmask    = bus_wdata[NCNT-1:0];
    assign unit_clr = bus_wen && (kind == K_GCTRL) && bus_wdata[1];

    // Global enable: loaded from bit 0 of every control write
    always_ff @(posedge clk) begin
        if (!rst_n)                             gen_en_q <= 1'b0;
        else if (bus_wen && (kind == K_GCTRL))  gen_en_q <= bus_wdata[0];
    end

    // Counter enable mask with write-one set and clear
    always_ff @(posedge clk) begin
        if (!rst_n || unit_clr)                 en_q <= '0;
        else if (bus_wen && (kind == K_ENSET))  en_q <= en_q | wmask;
        else if (bus_wen && (kind == K_ENCLR))  en_q <= en_q & ~wmask;
    end

    // Interrupt enable mask with write-one set and clear
    always_ff @(posedge clk) begin
        if (!rst_n || unit_clr)                 inten_q <= '0;
        else if (bus_wen && (kind == K_IESET))  inten_q <= inten_q | wmask;
        else if (bus_wen && (kind == K_IECLR))  inten_q <= inten_q & ~wmask;
    end

    // Sticky overflow status: a new wrap wins over a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n || unit_clr) ovf_q <= '0;
        else if (bus_wen && (kind == K_OVF)) ovf_q <= (ovf_q & ~wmask) | wrap_v;
        else                    ovf_q <= ovf_q | wrap_v;
    end

    for (genvar g = 0; g < NCNT; g++) begin : g_slice
        ucnt_slice #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_slice (
            .clk       (clk),
            .rst_n     (rst_n),
            .unit_clr  (unit_clr),
            .cnt_we    (bus_wen && (kind == K_CNT) && (idx == IDX_W'(g))),
            .cnt_wdata (bus_wdata[CNT_W-1:0]),
            .sel_we    (bus_wen && (kind == K_SEL) && (idx == IDX_W'(g))),
            .sel_wdata (bus_wdata[SEL_W-1:0]),
            .run       (gen_en_q && en_q[g]),
            .port0_ev  (port0_ev),
            .port1_ev  (port1_ev),
            .ext_ev    (ext_ev),
            .cnt_q     (cnt_arr[g]),
            .sel_q     (sel_arr[g]),
            .wrap      (wrap_v[g])
        );
    end

    // Combinational read mux; control words and holes read as zero
    always_comb begin
        case (kind)
            K_CNT:            bus_rdata = DATA_W'(cnt_arr[idx]);
            K_SEL:            bus_rdata = DATA_W'(sel_arr[idx]);
            K_GCTRL:          bus_rdata = DATA_W'(gen_en_q);
            K_ENSET, K_ENCLR: bus_rdata = DATA_W'(en_q);
            K_IESET, K_IECLR: bus_rdata = DATA_W'(inten_q);
            K_OVF:            bus_rdata = DATA_W'(ovf_q);
            default:          bus_rdata = '0;
        endcase
    end

    // Level interrupt from enabled overflow bits
    assign irq = |(ovf_q & inten_q);

endmodule

// File: rtl/ucnt_chk.sv
// Assertion checker for ucnt_unit, bound into every instance below.
module ucnt_chk
    import ucnt_pkg::*;
#(
    parameter int NCNT   = 8,
    parameter int CNT_W  = 64,
    parameter int DATA_W = 64,
    parameter int ADDR_W = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_wen,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic [DATA_W-1:0]          bus_wdata,
    input logic                       irq,
    input logic                       gen_en_q,
    input logic [NCNT-1:0]            en_q,
    input logic [NCNT-1:0]            inten_q,
    input logic [NCNT-1:0]            ovf_q,
    input logic [NCNT-1:0]            wrap_v,
    input logic [NCNT-1:0][CNT_W-1:0] cnt_arr
);

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (en_q == '0 && inten_q == '0 && ovf_q == '0 && !gen_en_q && !irq));

    p_stopped_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!gen_en_q && !bus_wen) |=> $stable(cnt_arr));

    p_gen_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_addr == ADDR_W'(A_GCTRL)) |=> (gen_en_q == $past(bus_wdata[0])));

    p_enable_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_addr == ADDR_W'(A_ENSET)) |=> (en_q == ($past(en_q) | $past(bus_wdata[NCNT-1:0]))));

    p_ovf_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_addr == ADDR_W'(A_OVF)) |=> ((ovf_q & $past(bus_wdata[NCNT-1:0] & ~wrap_v)) == '0));

    p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (((ovf_q & inten_q) != '0) && !bus_wen) |=> irq);

    p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_addr == ADDR_W'(A_CNT_BASE)) |=> (cnt_arr[0] == $past(bus_wdata[CNT_W-1:0])));

    p_unit_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_addr == ADDR_W'(A_GCTRL) && bus_wdata[1]) |=>
        (en_q == '0 && inten_q == '0 && ovf_q == '0 && cnt_arr == '0));

endmodule

bind ucnt_unit ucnt_chk #(
    .NCNT(NCNT), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wen   (bus_wen),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .gen_en_q  (gen_en_q),
    .en_q      (en_q),
    .inten_q   (inten_q),
    .ovf_q     (ovf_q),
    .wrap_v    (wrap_v),
    .cnt_arr   (cnt_arr)
);

// File: tb/tb_ucnt_unit.sv
// Self-checking bench for ucnt_unit: directed corner cases plus seeded
// random traffic, compared against a cycle model written from the requirements.
module tb_ucnt_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wen = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic [4:0]  port0_ev = '0;
    logic [4:0]  port1_ev = '0;
    logic        ext_ev = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ucnt_unit dut (
        .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .port0_ev(port0_ev),
        .port1_ev(port1_ev), .ext_ev(ext_ev), .irq(irq)
    );

    // ---------------- reference model ----------------
    logic [63:0] m_cnt [8];
    logic [7:0]  m_sel [8];
    logic [7:0]  m_en, m_ie, m_ovf;
    logic        m_gen;
    logic [63:0] t_next [8];
    logic [7:0]  t_wrap, t_clr;

    function automatic logic strobe_of(input logic [7:0] code, input logic [4:0] a,
                                       input logic [4:0] b, input logic x);
        case (code)
            8'h00: return a[0];
            8'h10: return a[1];
            8'h14: return a[2];
            8'h20: return a[3];
            8'h24: return a[4];
            8'h40: return b[0];
            8'h50: return b[1];
            8'h54: return b[2];
            8'h60: return b[3];
            8'h64: return b[4];
            8'h80: return x;
            default: return 1'b0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) begin m_cnt[i] = '0; m_sel[i] = '0; end
            m_en = '0; m_ie = '0; m_ovf = '0; m_gen = 1'b0;
        end else begin
            t_wrap = '0;
            t_clr  = '0;
            for (int i = 0; i < 8; i++) begin
                t_next[i] = m_cnt[i];
                if (m_gen && m_en[i] && strobe_of(m_sel[i], port0_ev, port1_ev, ext_ev)) begin
                    if (&m_cnt[i]) t_wrap[i] = 1'b1;
                    t_next[i] = m_cnt[i] + 64'd1;
                end
            end
            if (bus_wen) begin
                if (bus_addr < 8'h08) begin
                    t_next[bus_addr[2:0]] = bus_wdata;
                    t_wrap[bus_addr[2:0]] = 1'b0;
                end else if (bus_addr >= 8'h40 && bus_addr < 8'h48) begin
                    m_sel[bus_addr[2:0]] = bus_wdata[7:0];
                end else begin
                    case (bus_addr)
                        8'h80: m_gen = bus_wdata[0];
                        8'h82: m_en = m_en | bus_wdata[7:0];
                        8'h83: m_en = m_en & ~bus_wdata[7:0];
                        8'h84: m_ie = m_ie | bus_wdata[7:0];
                        8'h85: m_ie = m_ie & ~bus_wdata[7:0];
                        8'h88: t_clr = bus_wdata[7:0];
                        default: ;
                    endcase
                end
            end
            m_ovf = (m_ovf & ~t_clr) | t_wrap;
            for (int i = 0; i < 8; i++) m_cnt[i] = t_next[i];
            if (bus_wen && bus_addr == 8'h80 && bus_wdata[1]) begin
                for (int i = 0; i < 8; i++) begin m_cnt[i] = '0; m_sel[i] = '0; end
                m_en = '0; m_ie = '0; m_ovf = '0;
            end
        end
    end

    function automatic logic [63:0] exp_rd(input logic [7:0] a);
        if (a < 8'h08) return m_cnt[a[2:0]];
        if (a >= 8'h40 && a < 8'h48) return {56'd0, m_sel[a[2:0]]};
        case (a)
            8'h80:        return {63'd0, m_gen};
            8'h82, 8'h83: return {56'd0, m_en};
            8'h84, 8'h85: return {56'd0, m_ie};
            8'h88:        return {56'd0, m_ovf};
            default:      return 64'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        if (a < 8'h08) return "R2";
        if (a >= 8'h40 && a < 8'h48) return "R3";
        case (a)
            8'h80:        return "R5";
            8'h82, 8'h83: return "R6";
            8'h84, 8'h85: return "R7";
            8'h88:        return "R8";
            default:      return "R12";
        endcase
    endfunction

    // ---------------- check and drive helpers ----------------
    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Write one word; starts and ends at a falling edge with one rising edge inside
    task automatic wr(input logic [7:0] a, input logic [63:0] d);
        bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Read at the current falling edge, compare with an explicit value
    task automatic rd_exp(input logic [7:0] a, input logic [63:0] e, input string tag);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, e);
        chk(tag, exp_rd(a), e);
    endtask

    // Read at the current falling edge, compare with the model
    task automatic rd_model(input logic [7:0] a);
        bus_addr = a;
        #1;
        chk(tag_of(a), bus_rdata, exp_rd(a));
    endtask

    task automatic irq_exp(input logic e, input string tag);
        #1;
        chk(tag, {63'd0, irq}, {63'd0, e});
    endtask

    task automatic check_all();
        for (int i = 0; i < 8; i++) rd_model(8'(i));
        for (int i = 0; i < 8; i++) rd_model(8'(8'h40 + i));
        rd_model(8'h21); rd_model(8'h80); rd_model(8'h82); rd_model(8'h83);
        rd_model(8'h84); rd_model(8'h85); rd_model(8'h88); rd_model(8'h97);
        irq_exp(|(m_ovf & m_ie), "R9");
    endtask

    function automatic logic [7:0] pick_addr(input int unsigned r, input int unsigned s);
        case (r % 12)
            0, 10:   return 8'(s % 8);
            1, 11:   return 8'(8'h40 + s % 8);
            2:       return 8'(8'h20 + s % 8);
            3:       return 8'h80;
            4:       return 8'h82;
            5:       return 8'h83;
            6:       return 8'h84;
            7:       return 8'h85;
            8:       return 8'h88;
            default: return 8'(8'h90 + s % 16);
        endcase
    endfunction

    localparam logic [7:0] CODES [11] = '{8'h00, 8'h10, 8'h14, 8'h20, 8'h24,
                                          8'h40, 8'h50, 8'h54, 8'h60, 8'h64, 8'h80};

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        void'($urandom(32'd7741));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd_exp(8'h00, 64'd0, "R1");
        rd_exp(8'h47, 64'd0, "R1");
        rd_exp(8'h80, 64'd0, "R1");
        rd_exp(8'h82, 64'd0, "R1");
        rd_exp(8'h84, 64'd0, "R1");
        rd_exp(8'h88, 64'd0, "R1");
        irq_exp(1'b0, "R1");

        // R3: each code counts only its own strobe while all others are high
        for (int i = 0; i < 11; i++) begin
            port0_ev = '1; port1_ev = '1; ext_ev = 1'b1;
            if (i < 5) port0_ev[i] = 1'b0;
            else if (i < 10) port1_ev[i-5] = 1'b0;
            else ext_ev = 1'b0;
            wr(8'h80, 64'd3);
            wr(8'h40, {56'd0, CODES[i]});
            wr(8'h82, 64'h01);
            if (i < 5) port0_ev[i] = 1'b1;
            else if (i < 10) port1_ev[i-5] = 1'b1;
            else ext_ev = 1'b1;
            idle(5);
            if (i < 5) port0_ev[i] = 1'b0;
            else if (i < 10) port1_ev[i-5] = 1'b0;
            else ext_ev = 1'b0;
            rd_exp(8'h00, 64'd5, "R3");
        end

        // R4: unassigned code with every strobe high
        port0_ev = '1; port1_ev = '1; ext_ev = 1'b1;
        wr(8'h80, 64'd3);
        wr(8'h40, 64'h11);
        wr(8'h82, 64'h01);
        idle(6);
        rd_exp(8'h00, 64'd0, "R4");
        rd_exp(8'h40, 64'h11, "R3");

        // R2/R5: counter 1 on cycles; global stop then resume
        wr(8'h41, 64'h00);
        wr(8'h82, 64'h02);
        idle(4);
        rd_exp(8'h01, 64'd4, "R2");
        wr(8'h80, 64'd0);
        rd_exp(8'h01, 64'd5, "R5");
        idle(3);
        rd_exp(8'h01, 64'd5, "R5");
        rd_exp(8'h80, 64'd0, "R5");
        wr(8'h80, 64'd1);
        idle(2);
        rd_exp(8'h01, 64'd7, "R2");
        rd_exp(8'h80, 64'd1, "R5");

        // R10: load wins over a same-cycle increment
        wr(8'h01, 64'd100);
        rd_exp(8'h01, 64'd100, "R10");
        idle(1);
        rd_exp(8'h01, 64'd101, "R10");

        // R6/R7: write-one set and clear, both words read the mask
        port0_ev = '0; port1_ev = '0; ext_ev = 1'b0;
        wr(8'h80, 64'd2);
        wr(8'h82, 64'h0F);
        wr(8'h82, 64'h30);
        rd_exp(8'h82, 64'h3F, "R6");
        rd_exp(8'h83, 64'h3F, "R6");
        wr(8'h83, 64'h05);
        rd_exp(8'h82, 64'h3A, "R6");
        wr(8'h83, 64'hFF);
        rd_exp(8'h83, 64'h00, "R6");
        wr(8'h84, 64'h81);
        wr(8'h84, 64'h02);
        wr(8'h85, 64'h01);
        rd_exp(8'h84, 64'h82, "R7");
        rd_exp(8'h85, 64'h82, "R7");
        wr(8'h85, 64'hFF);
        rd_exp(8'h84, 64'h00, "R7");

        // R8/R9: wrap of counter 3 raises overflow and interrupt
        wr(8'h80, 64'd3);
        wr(8'h03, 64'hFFFF_FFFF_FFFF_FFFE);
        wr(8'h84, 64'h08);
        wr(8'h82, 64'h08);
        port0_ev[0] = 1'b1;
        idle(1);
        rd_exp(8'h03, 64'hFFFF_FFFF_FFFF_FFFF, "R8");
        rd_exp(8'h88, 64'h00, "R8");
        irq_exp(1'b0, "R9");
        idle(1);
        port0_ev[0] = 1'b0;
        rd_exp(8'h03, 64'd0, "R8");
        rd_exp(8'h88, 64'h08, "R8");
        irq_exp(1'b1, "R9");
        wr(8'h88, 64'hF7);
        rd_exp(8'h88, 64'h08, "R8");
        wr(8'h85, 64'h08);
        irq_exp(1'b0, "R9");
        wr(8'h84, 64'h08);
        irq_exp(1'b1, "R9");
        wr(8'h88, 64'hFF);
        rd_exp(8'h88, 64'h00, "R8");
        irq_exp(1'b0, "R9");

        // R8: wrap and clear in the same cycle leaves the bit set
        wr(8'h05, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(8'h82, 64'h20);
        port0_ev[0] = 1'b1;
        wr(8'h88, 64'hFF);
        port0_ev[0] = 1'b0;
        rd_exp(8'h88, 64'h20, "R8");
        rd_exp(8'h05, 64'd0, "R8");

        // R12: control words and holes read zero and change nothing
        wr(8'h21, 64'hDEAD_BEEF_0000_00FF);
        wr(8'h9C, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(8'hFF, 64'h1234);
        rd_exp(8'h21, 64'd0, "R12");
        rd_exp(8'h9C, 64'd0, "R12");
        rd_exp(8'h81, 64'd0, "R12");
        check_all();

        // R11: unit reset clears everything, self-clears, takes enable
        wr(8'h80, 64'd3);
        rd_exp(8'h80, 64'd1, "R11");
        rd_exp(8'h82, 64'd0, "R11");
        rd_exp(8'h84, 64'd0, "R11");
        rd_exp(8'h88, 64'd0, "R11");
        rd_exp(8'h03, 64'd0, "R11");
        rd_exp(8'h41, 64'd0, "R11");
        wr(8'h80, 64'd2);
        rd_exp(8'h80, 64'd0, "R11");

        // Random traffic against the model
        for (int it = 0; it < 3000; it++) begin
            int unsigned op;
            logic [7:0] a;
            op = $urandom % 10;
            port0_ev = 5'($urandom);
            port1_ev = 5'($urandom);
            ext_ev = 1'($urandom);
            a = pick_addr($urandom, $urandom);
            if (op < 4) begin
                idle(1);
            end else if (op < 7) begin
                v = {$urandom, $urandom};
                if (a < 8'h08 && ($urandom % 2 == 1)) v = {40'hFF_FFFF_FFFF, 24'($urandom % 40) + 24'hFF_FFD0};
                if (a >= 8'h40 && a < 8'h48) v = {56'd0, ($urandom % 4 == 0) ? 8'($urandom) : CODES[$urandom % 11]};
                if (a == 8'h80) v = {62'd0, ($urandom % 10 == 0), ($urandom % 5 != 0)};
                wr(a, v);
            end else begin
                rd_model(a);
                irq_exp(|(m_ovf & m_ie), "R9");
                idle(1);
            end
        end
        check_all();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule